// File: doc/BRIEF.md
# FIFO Threshold Offset Programming Port

This block holds the two programmable thresholds that a FIFO's flag logic compares against: the empty offset, which sets how close to empty the almost-empty indication fires, and the full offset, which does the same for almost-full. It does not hold FIFO storage and does not compute any flag. It only stores the two values, lets them be loaded from the FIFO's write data bus, and lets them be read back over the FIFO's read data bus. The flag logic reads the current values directly from two output buses.

Loading and readback share one active-low load strobe. A load happens on the write clock when the strobe and the active-low write enable are both low. A readback happens on the read clock when the strobe and the active-low read enable are both low. Each side walks the two registers through its own pointer, in the order empty offset, full offset, then back to the empty offset. Readback is only available in the standard mode. When the FIFO runs in first-word-fall-through mode, read requests to the offsets are ignored. A write and a read of the offsets should not be issued together. If they are, the write is performed and the readback word is flagged as not valid. This conflict is judged from the write-side strobe levels as seen at the read clock edge, so the two clocks are expected to share edges when this matters.

Top module: `ofs_prog_port`

## Requirements
- R1: When `load_n` and `wr_en_n` are both low at a rising `wr_clk` edge, the offset register chosen by the write pointer takes `wr_data[AW-1:0]`, where AW = log2(DEPTH) (8 bits at DEPTH 256).
- R2: The write pointer starts at the empty offset, moves to the full offset after one write, and wraps back to the empty offset after the next. Every write advances it by exactly one.
- R3: At a `wr_clk` edge where `load_n` is high or `wr_en_n` is high, neither offset changes and the write pointer does not move.
- R4: In standard mode (`fall_through` low), when `load_n` and `rd_en_n` are both low and `wr_en_n` is high at a rising `rd_clk` edge, `rb_data` takes the offset chosen by the read pointer on bits [AW-1:0], with all higher bits 0, and `rb_valid` goes to 1.
- R5: The read pointer follows the same empty-then-full, wrapping order as the write pointer. It advances once per completed readback and is never moved by writes.
- R6: While `fall_through` is high, a read request leaves `rb_data`, `rb_valid` and the read pointer unchanged.
- R7: When a write (R1) and a standard-mode read request occur at the same edge, the write is performed, `rb_valid` goes to 0, `rb_data` holds its value, and the read pointer does not move.
- R8: While `rst_n` is low, both offsets take the depth-derived default: 31 for DEPTH 256, 63 for DEPTH 512, and 127 for larger depths. At the same time both pointers return to the empty offset, `rb_data` clears to 0 and `rb_valid` clears to 0.
- R9: `empty_ofs` and `full_ofs` always show the current contents of the two offset registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write clock; loads are taken on its rising edge |
| rd_clk | input | 1 | Read clock; readbacks are taken on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| load_n | input | 1 | Active-low strobe that routes accesses to the offset registers |
| wr_en_n | input | 1 | Active-low write enable |
| rd_en_n | input | 1 | Active-low read enable |
| fall_through | input | 1 | High selects first-word-fall-through mode, which blocks readback |
| wr_data | input | BUS_W | Write data bus; the offset is taken from its low AW bits |
| empty_ofs | output | AW | Current empty offset |
| full_ofs | output | AW | Current full offset |
| rb_data | output | BUS_W | Readback word, with the offset zero-extended on the low bits |
| rb_valid | output | 1 | High when rb_data holds a good readback |

## Verification
Loads are tried with distinct values whose upper bus bits are set. This separates a correct truncation to the low bits from a wrong slice, and a write to the empty offset from a write to the full offset. Writes are interleaved with blocked writes (enable high, strobe high) and then with reads, so that a pointer that advances on blocked strobes, or one shared between the two sides, produces the wrong value sequence. A read issued in fall-through mode and a read issued together with a write each follow a valid readback whose value differs from what the blocked access would have returned. A reset issued partway through the run shows that the defaults and the pointer positions come back.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

   // number of programmable offsets held by the port
   localparam int NUM_OFS = 2;

   // entry order walked by both sequencing pointers
   typedef enum logic [0:0] {
      SEL_EMPTY = 1'b0,
      SEL_FULL  = 1'b1
   } ofs_sel_e;

   // depth-derived reset value of an offset
   function automatic int dflt_offset(input int depth);
      if (depth == 256)      return 31;
      else if (depth == 512) return 63;
      else                   return 127;
   endfunction

endpackage

// File: rtl/ofs_step_ptr.sv
module ofs_step_ptr (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output ofs_pkg::ofs_sel_e sel
);
   import ofs_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sel <= SEL_EMPTY;
      else if (step)
         sel <= (sel == SEL_FULL) ? SEL_EMPTY : SEL_FULL;
   end

endmodule

// File: rtl/ofs_wr_bank.sv
module ofs_wr_bank #(
   parameter int AW        = 8,
   parameter int EMPTY_DEF = 31,
   parameter int FULL_DEF  = 31
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  load_n,
   input  logic                                  wr_en_n,
   input  logic [AW-1:0]                         wr_val,
   output logic [ofs_pkg::NUM_OFS-1:0][AW-1:0]   bank,
   output ofs_pkg::ofs_sel_e                     wr_sel
);
   import ofs_pkg::*;

   logic wr_go;
   assign wr_go = !load_n && !wr_en_n;

   ofs_step_ptr i_wptr (
      .clk  (clk),
      .rst_n(rst_n),
      .step (wr_go),
      .sel  (wr_sel)
   );

   for (genvar g = 0; g < NUM_OFS; g++) begin : g_ofs
      localparam int RST_INT = (g == 0) ? EMPTY_DEF : FULL_DEF;
      localparam logic [AW-1:0] RST_VAL = RST_INT[AW-1:0];
      logic [AW-1:0] q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= RST_VAL;
         else if (wr_go && (int'(wr_sel) == g))
            q <= wr_val;
      end

      assign bank[g] = q;
   end

endmodule

// File: rtl/ofs_rb_port.sv
module ofs_rb_port #(
   parameter int AW    = 8,
   parameter int BUS_W = 18
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  load_n,
   input  logic                                  rd_en_n,
   input  logic                                  wr_en_n,
   input  logic                                  fall_through,
   input  logic [ofs_pkg::NUM_OFS-1:0][AW-1:0]   bank,
   output logic [BUS_W-1:0]                      rb_data,
   output logic                                  rb_valid,
   output ofs_pkg::ofs_sel_e                     rd_sel
);
   import ofs_pkg::*;

   logic             rd_gate;
   logic             clash;
   logic             rd_take;
   logic [AW-1:0]    sel_val;
   logic [BUS_W-1:0] sel_word;

   // readback only in standard mode; a simultaneous write wins
   assign rd_gate = !load_n && !rd_en_n && !fall_through;
   assign clash   = rd_gate && !wr_en_n;
   assign rd_take = rd_gate && !clash;

   ofs_step_ptr i_rptr (
      .clk  (clk),
      .rst_n(rst_n),
      .step (rd_take),
      .sel  (rd_sel)
   );

   assign sel_val = bank[rd_sel];

   if (BUS_W > AW) begin : g_pad
      assign sel_word = {{(BUS_W-AW){1'b0}}, sel_val};
   end else begin : g_flat
      assign sel_word = sel_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rb_data  <= '0;
         rb_valid <= 1'b0;
      end else if (clash) begin
         rb_valid <= 1'b0;
      end else if (rd_take) begin
         rb_data  <= sel_word;
         rb_valid <= 1'b1;
      end
   end

endmodule

// File: rtl/ofs_prog_port.sv
module ofs_prog_port #(
   parameter int DEPTH    = 256,
   parameter int BUS_W    = 18,
   parameter int FULL_DEF = ofs_pkg::dflt_offset(DEPTH)
) (
   input  logic                     wr_clk,
   input  logic                     rd_clk,
   input  logic                     rst_n,
   input  logic                     load_n,
   input  logic                     wr_en_n,
   input  logic                     rd_en_n,
   input  logic                     fall_through,
   input  logic [BUS_W-1:0]         wr_data,
   output logic [$clog2(DEPTH)-1:0] empty_ofs,
   output logic [$clog2(DEPTH)-1:0] full_ofs,
   output logic [BUS_W-1:0]         rb_data,
   output logic                     rb_valid
);
   import ofs_pkg::*;

   localparam int AW        = $clog2(DEPTH);
   localparam int EMPTY_DEF = dflt_offset(DEPTH);

   // elaboration-time parameter checks
   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 256) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 256");
   end
   if (AW > BUS_W) begin : g_bad_bus
      $error("BUS_W must hold a full offset");
   end
   if (FULL_DEF < 0 || FULL_DEF >= DEPTH) begin : g_bad_full
      $error("FULL_DEF must lie below DEPTH");
   end

   logic [NUM_OFS-1:0][AW-1:0] bank;
   ofs_sel_e                   wr_sel;
   ofs_sel_e                   rd_sel;

   if (BUS_W > AW) begin : g_hi
      logic unused_hi_bits;
      assign unused_hi_bits = ^wr_data[BUS_W-1:AW];
   end

   ofs_wr_bank #(
      .AW       (AW),
      .EMPTY_DEF(EMPTY_DEF),
      .FULL_DEF (FULL_DEF)
   ) i_wr_bank (
      .clk    (wr_clk),
      .rst_n  (rst_n),
      .load_n (load_n),
      .wr_en_n(wr_en_n),
      .wr_val (wr_data[AW-1:0]),
      .bank   (bank),
      .wr_sel (wr_sel)
   );

   ofs_rb_port #(
      .AW   (AW),
      .BUS_W(BUS_W)
   ) i_rb_port (
      .clk         (rd_clk),
      .rst_n       (rst_n),
      .load_n      (load_n),
      .rd_en_n     (rd_en_n),
      .wr_en_n     (wr_en_n),
      .fall_through(fall_through),
      .bank        (bank),
      .rb_data     (rb_data),
      .rb_valid    (rb_valid),
      .rd_sel      (rd_sel)
   );

   assign empty_ofs = bank[SEL_EMPTY];
   assign full_ofs  = bank[SEL_FULL];

endmodule

// File: rtl/ofs_prog_port_chk.sv
module ofs_prog_port_chk #(
   parameter int AW    = 8,
   parameter int BUS_W = 18
) (
   input logic             wr_clk,
   input logic             rd_clk,
   input logic             rst_n,
   input logic             load_n,
   input logic             wr_en_n,
   input logic             rd_en_n,
   input logic             fall_through,
   input logic [BUS_W-1:0] wr_data,
   input logic [AW-1:0]    empty_ofs,
   input logic [AW-1:0]    full_ofs,
   input logic [BUS_W-1:0] rb_data,
   input logic             rb_valid,
   input logic             wr_sel,
   input logic             rd_sel
);

   // R1: a write aimed at the empty entry lands there
   assert_load_empty_R1: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (!load_n && !wr_en_n && !wr_sel) |=> (empty_ofs == $past(wr_data[AW-1:0])));

   // R2: every write moves the write pointer
   assert_wptr_step_R2: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (!load_n && !wr_en_n) |=> (wr_sel != $past(wr_sel)));

   // R3: blocked write strobes change nothing
   assert_no_write_R3: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (load_n || wr_en_n) |=> ($stable(empty_ofs) && $stable(full_ofs) && $stable(wr_sel)));

   // R4: a clean standard-mode read yields a valid zero-extended word
   assert_rb_valid_R4: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (!load_n && wr_en_n && !rd_en_n && !fall_through) |=> (rb_valid && ((rb_data >> AW) == '0)));

   // R6: fall-through mode blocks readback entirely
   assert_ft_block_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
      fall_through |=> ($stable(rb_data) && $stable(rb_valid) && $stable(rd_sel)));

   // R7: a read colliding with a write is dropped and flagged invalid
   assert_clash_R7: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (!load_n && !wr_en_n && !rd_en_n && !fall_through) |=> (!rb_valid && $stable(rb_data) && $stable(rd_sel)));

endmodule

bind ofs_prog_port ofs_prog_port_chk #(
   .AW   (AW),
   .BUS_W(BUS_W)
) i_chk (
   .wr_clk      (wr_clk),
   .rd_clk      (rd_clk),
   .rst_n       (rst_n),
   .load_n      (load_n),
   .wr_en_n     (wr_en_n),
   .rd_en_n     (rd_en_n),
   .fall_through(fall_through),
   .wr_data     (wr_data),
   .empty_ofs   (empty_ofs),
   .full_ofs    (full_ofs),
   .rb_data     (rb_data),
   .rb_valid    (rb_valid),
   .wr_sel      (wr_sel),
   .rd_sel      (rd_sel)
);

// File: tb/test_ofs_prog_port.sv
module test_ofs_prog_port;

   localparam int DEPTH = 256;
   localparam int BUS_W = 18;
   localparam int AW    = 8;
   localparam int DEF   = 31;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             load_n = 1'b1;
   logic             wr_en_n = 1'b1;
   logic             rd_en_n = 1'b1;
   logic             fall_through = 1'b0;
   logic [BUS_W-1:0] wr_data = '0;
   logic [AW-1:0]    empty_ofs;
   logic [AW-1:0]    full_ofs;
   logic [BUS_W-1:0] rb_data;
   logic             rb_valid;

   always #10 clk = ~clk;   // 50 MHz

   ofs_prog_port #(.DEPTH(DEPTH), .BUS_W(BUS_W)) i_ofs_prog_port (
      .wr_clk      (clk),
      .rd_clk      (clk),
      .rst_n       (rst_n),
      .load_n      (load_n),
      .wr_en_n     (wr_en_n),
      .rd_en_n     (rd_en_n),
      .fall_through(fall_through),
      .wr_data     (wr_data),
      .empty_ofs   (empty_ofs),
      .full_ofs    (full_ofs),
      .rb_data     (rb_data),
      .rb_valid    (rb_valid)
   );

   typedef struct {
      logic [BUS_W-1:0] data;
      logic             valid;
      logic [AW-1:0]    e;
      logic [AW-1:0]    f;
      string            tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   fails  = 0;
   bit   done   = 0;

   // reference model state
   logic [AW-1:0]    m_ofs[2];
   int               m_wp, m_rp;
   logic [BUS_W-1:0] m_data;
   logic             m_valid;

   task automatic model_reset();
      m_ofs[0] = DEF; m_ofs[1] = DEF;
      m_wp = 0; m_rp = 0; m_data = '0; m_valid = 1'b0;
   endtask

   // driver: one clock of stimulus, expected result pushed after the edge
   task automatic cyc(input logic ld, input logic we, input logic re,
                      input logic ft, input logic [BUS_W-1:0] wd, input string tag);
      exp_t x;
      logic wr, rd;
      @(negedge clk);
      load_n = ld; wr_en_n = we; rd_en_n = re; fall_through = ft; wr_data = wd;
      wr = !ld && !we;
      rd = !ld && !re && !ft;
      if (rd && wr) begin
         m_valid = 1'b0;
      end else if (rd) begin
         m_data  = {{(BUS_W-AW){1'b0}}, m_ofs[m_rp]};
         m_valid = 1'b1;
         m_rp    = 1 - m_rp;
      end
      if (wr) begin
         m_ofs[m_wp] = wd[AW-1:0];
         m_wp = 1 - m_wp;
      end
      @(posedge clk);
      #1;
      x.data = m_data; x.valid = m_valid; x.e = m_ofs[0]; x.f = m_ofs[1]; x.tag = tag;
      q.push_back(x);
   endtask

   task automatic idle(input string tag);
      cyc(1'b1, 1'b1, 1'b1, 1'b0, '0, tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      load_n = 1'b1; wr_en_n = 1'b1; rd_en_n = 1'b1; fall_through = 1'b0;
      model_reset();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // monitor: compares each pushed expectation one half-cycle later
   always @(negedge clk) begin
      exp_t x;
      if (q.size() > 0) begin
         x = q.pop_front();
         checks++;
         if (rb_data !== x.data || rb_valid !== x.valid ||
             empty_ofs !== x.e || full_ofs !== x.f) begin
            fails++;
            $display("FAIL %s: rb_data=%h rb_valid=%b empty=%0d full=%0d, expected rb_data=%h rb_valid=%b empty=%0d full=%0d",
                     x.tag, rb_data, rb_valid, empty_ofs, full_ofs,
                     x.data, x.valid, x.e, x.f);
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      model_reset();
      do_reset();
      idle("R8 reset defaults");
      // R4/R5/R8: read both defaults in pointer order
      cyc(1'b0, 1'b1, 1'b0, 1'b0, '0, "R4 R8 read empty default");
      cyc(1'b0, 1'b1, 1'b0, 1'b0, '0, "R5 R8 read full default");
      // R1/R2/R9: loads with upper bus bits set
      cyc(1'b0, 1'b0, 1'b1, 1'b0, 18'h3FF05, "R1 R9 load empty");
      cyc(1'b0, 1'b0, 1'b1, 1'b0, 18'h2AAFE, "R2 load full");
      // R3: blocked writes
      cyc(1'b0, 1'b1, 1'b1, 1'b0, 18'h00044, "R3 wr_en_n high ignored");
      cyc(1'b1, 1'b0, 1'b1, 1'b0, 18'h00055, "R3 load_n high ignored");
      cyc(1'b0, 1'b0, 1'b1, 1'b0, 18'h10012, "R2 wrap to empty");
      // R5: read pointer wrapped independently
      cyc(1'b0, 1'b1, 1'b0, 1'b0, '0, "R5 read empty after wrap");
      cyc(1'b0, 1'b1, 1'b0, 1'b0, '0, "R5 read full");
      idle("R4 readback holds");
      // R6: fall-through mode blocks readback
      cyc(1'b0, 1'b1, 1'b0, 1'b1, '0, "R6 fall-through read ignored");
      cyc(1'b0, 1'b1, 1'b0, 1'b1, '0, "R6 fall-through read ignored again");
      // R7: collision: write to full wins, readback invalid
      cyc(1'b0, 1'b0, 1'b0, 1'b0, 18'h00377, "R7 write wins collision");
      cyc(1'b0, 1'b1, 1'b0, 1'b0, '0, "R7 read pointer not moved");
      cyc(1'b0, 1'b1, 1'b0, 1'b0, '0, "R1 R5 read back collided write");
      idle("R9 offsets steady");
      // R8: reset mid-run restores everything
      @(negedge clk);
      do_reset();
      idle("R8 reset restores defaults");
      cyc(1'b0, 1'b1, 1'b0, 1'b0, '0, "R8 read pointer back at empty");
      cyc(1'b0, 1'b0, 1'b1, 1'b0, 18'h000C3, "R8 write pointer back at empty");
      idle("R9 final state");
      repeat (2) @(negedge clk);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule